// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a bus-attached register bank that a host reaches over a two-wire SMBus link. The host picks a starting index and then moves several bytes in one transfer. A write carries the index, then a byte count, then the data bytes. A read carries the index, then a repeated start and the read address. The slave answers with a count byte first and then the data bytes, beginning at the chosen index.

The count byte returned on a read comes from a register inside the bank, so software sets the read length by writing that register. Both wires are oversampled by the system clock, synchronised and filtered. Start and stop are then decoded from the cleaned signals. The slave drives its data line only by pulling it low.

The current contents of every register byte appear on a flat output bus. A one-cycle strobe with the byte index marks each byte that is actually stored.

Top module: `smb_regblk`

## Requirements
- R1: The 7-bit slave address is 7'h68 (write/read bytes D0h/D1h) when `addr_sel` is 0 and 7'h60 (C0h/C1h) when it is 1. Only the selected address is acknowledged.
- R2: When the address byte does not match, the slave does not acknowledge. It leaves SDA released and ignores all bytes until the next start condition.
- R3: In a block write (address with R/W bit 0, index N, count X, data), every byte is acknowledged. The data bytes go to indices N, N+1, and so on.
- R4: Data bytes sent after X bytes have already been stored are acknowledged but discarded.
- R5: In a block read (write address, index N, repeated start, address with R/W bit 1), the slave first sends the value of register byte 8 (the count byte). It then sends bytes N, N+1, and so on for as long as the host acknowledges.
- R6: A host NACK after a read byte ends the transfer. The slave releases SDA and does not drive it again before a new start.
- R7: Bytes 6 and 7 (identification) are read-only. Writes to them are acknowledged and leave them unchanged.
- R8: Writes to indices at or above NUM_REGS (22) are acknowledged and discarded. Reads from those indices return 00h.
- R9: The pull-down output changes only while SCL is low. The only exception is a release caused by a start or stop.
- R10: Reset loads the default values: byte 1 = FFh, byte 2 = 3Fh (enable bits 5:0 set), byte 6 = 13h, byte 7 = 42h, byte 8 = 04h, and 00h in all other bytes.
- R11: `wr_stb_o` pulses for one cycle, with `wr_idx_o`, for each byte stored. Discarded writes give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus value) |
| addr_sel | input | 1 | Selects the slave address pair |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain driver) |
| regs_o | output | NUM_REGS*8 | All register bytes, byte i at bits [8i+7:8i] |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_idx_o | output | 8 | Index of the byte just stored |

## Verification
The assertions run on every cycle. They check that SDA moves only while the filtered SCL is low, outside of start and stop. They check that SDA is released after an address miss and after a host NACK. They also check that the pointer steps once per data byte, that identification bytes never change, and that strobes follow a write request to an implemented index. The end-to-end behaviour needs the bench's host transactions to show it. This covers the address pair selected by the strap, the count byte leading each read, the data landing at the right indices, bytes beyond the count being dropped, and the zero fill past the last register.

// File: rtl/smb_regblk_pkg.sv
package smb_regblk_pkg;

  localparam int IDX_OUT_EN  = 1;
  localparam int IDX_MISC_EN = 2;
  localparam int IDX_REVVEND = 6;
  localparam int IDX_DEVICE  = 7;
  localparam int IDX_COUNT   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_DATA
  } rx_kind_t;

  function automatic logic is_read_only(input logic [7:0] idx);
    return (idx == 8'(IDX_REVVEND)) || (idx == 8'(IDX_DEVICE));
  endfunction

  function automatic logic [7:0] reg_default(input int idx, input logic [7:0] revvend,
                                             input logic [7:0] device, input logic [7:0] count);
    case (idx)
      IDX_OUT_EN:  return 8'hFF;
      IDX_MISC_EN: return 8'h3F;
      IDX_REVVEND: return revvend;
      IDX_DEVICE:  return device;
      IDX_COUNT:   return count;
      default:     return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      dout   <= 1'b1;
      cnt    <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (samp == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        dout <= samp;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_regblk_pkg::*;
#(
  parameter int         NUM_REGS      = 22,
  parameter logic [7:0] ID_REVVEND    = 8'h13,
  parameter logic [7:0] ID_DEVICE     = 8'h42,
  parameter logic [7:0] COUNT_DEFAULT = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            widx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_idx_o
);
  logic [7:0] mem [NUM_REGS];
  logic       accept;

  assign accept = we && (int'(widx) < NUM_REGS) && !is_read_only(widx);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= reg_default(g, ID_REVVEND, ID_DEVICE, COUNT_DEFAULT);
      else if (accept && widx == 8'(g))      mem[g] <= wdata;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o <= 1'b0;
      wr_idx_o <= 8'h00;
    end else begin
      wr_stb_o <= accept;
      wr_idx_o <= widx;
    end
  end

  assert_ro_revvend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem[IDX_REVVEND]));
  assert_ro_device_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem[IDX_DEVICE]));
  assert_stb_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (int'(wr_idx_o) < NUM_REGS));
  assert_stb_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(we));

endmodule

// File: rtl/smb_regblk.sv
module smb_regblk
  import smb_regblk_pkg::*;
#(
  parameter int         NUM_REGS      = 22,
  parameter int         SYNC_STAGES   = 2,
  parameter int         FILT_LEN      = 3,
  parameter logic [6:0] ADDR_SEL0     = 7'h68,
  parameter logic [6:0] ADDR_SEL1     = 7'h60,
  parameter logic [7:0] ID_REVVEND    = 8'h13,
  parameter logic [7:0] ID_DEVICE     = 8'h42,
  parameter logic [7:0] COUNT_DEFAULT = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_idx_o
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

  smb_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
  smb_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

  smb_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  bus_state_t state;
  rx_kind_t   kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, remaining, wr_data;
  logic [7:0] wr_idx_req;
  logic       wr_req, rd_dir, mack;

  // named events for the checks
  logic       own_hit, byte_done, addr_miss, data_done, host_nack_end;
  logic [6:0] own_addr;

  assign own_addr      = addr_sel ? ADDR_SEL1 : ADDR_SEL0;
  assign own_hit       = (shreg[7:1] == own_addr);
  assign byte_done     = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_miss     = byte_done && (kind == K_ADDR) && !own_hit;
  assign data_done     = byte_done && (kind == K_DATA);
  assign host_nack_end = (state == ST_TXACK) && scl_fall && !mack;

  function automatic logic [7:0] rd_byte(input logic [7:0] idx);
    if (int'(idx) < NUM_REGS) return regs_o[int'(idx)*8 +: 8];
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_ADDR;
      bitcnt     <= 4'd0;
      shreg      <= 8'h00;
      ptr        <= 8'h00;
      remaining  <= 8'h00;
      wr_req     <= 1'b0;
      wr_idx_req <= 8'h00;
      wr_data    <= 8'h00;
      rd_dir     <= 1'b0;
      mack       <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      if (start_ev) begin
        state  <= ST_RX;
        kind   <= K_ADDR;
        bitcnt <= 4'd0;
      end else if (stop_ev) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= 4'd0;
              state  <= ST_RXACK;
              case (kind)
                K_ADDR: begin
                  if (own_hit) begin
                    rd_dir <= shreg[0];
                    kind   <= K_IDX;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_IDX: begin
                  ptr  <= shreg;
                  kind <= K_CNT;
                end
                K_CNT: begin
                  remaining <= shreg;
                  kind      <= K_DATA;
                end
                default: begin
                  wr_req     <= (remaining != 8'h00);
                  wr_idx_req <= ptr;
                  wr_data    <= shreg;
                  ptr        <= ptr + 8'd1;
                  if (remaining != 8'h00) remaining <= remaining - 8'd1;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              if (rd_dir) begin
                rd_dir <= 1'b0;
                state  <= ST_TX;
                shreg  <= rd_byte(8'(IDX_COUNT));
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state  <= ST_TXACK;
                bitcnt <= 4'd0;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) mack <= ~sda_f;
            if (scl_fall) begin
              if (mack) begin
                shreg <= rd_byte(ptr);
                ptr   <= ptr + 8'd1;
                state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = (state == ST_RXACK) || ((state == ST_TX) && !shreg[7]);

  smb_regfile #(
    .NUM_REGS(NUM_REGS), .ID_REVVEND(ID_REVVEND), .ID_DEVICE(ID_DEVICE),
    .COUNT_DEFAULT(COUNT_DEFAULT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_req), .widx(wr_idx_req), .wdata(wr_data),
    .regs_o(regs_o), .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o));

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) && !$past(start_ev) && !$past(stop_ev) |-> !scl_f);
  assert_miss_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_pull_o);
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (ptr == $past(ptr) + 8'd1));
  assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_nack_end |=> !sda_pull_o);

endmodule

// File: tb/smb_regblk_test.sv
module smb_regblk_test;
  localparam int CLK_P = 10;
  localparam int Q     = 16;
  localparam int NREG  = 22;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull, wr_stb;
  logic [7:0] wr_idx;
  logic [NREG*8-1:0] regs;
  logic sda_bus;

  assign sda_bus = host_sda & ~sda_pull;

  always #(CLK_P/2) clk = ~clk;

  smb_regblk uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_sel(addr_sel),
    .sda_pull_o(sda_pull), .regs_o(regs), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx));

  int n_chk = 0, n_fail = 0, stb_cnt = 0, r9_viol = 0;
  logic prev_pull = 1'b0;
  bit done = 0;

  // table: {index, data0, data1, expect0, expect1, strobes}
  localparam logic [47:0] VEC [6] = '{
    48'h00_A5_3C_A5_3C_02,
    48'h04_11_22_11_22_02,
    48'h06_FF_00_13_42_00,
    48'h14_77_88_77_88_02,
    48'h15_99_AB_99_00_01,
    48'h05_5A_C3_5A_13_01
  };

  always @(negedge clk) begin
    if (wr_stb) stb_cnt++;
    if (rst_n && (sda_pull !== prev_pull) && scl) r9_viol++;
    prev_pull = sda_pull;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic bus_start;
    host_sda = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    host_sda = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; hold(Q); scl = 1'b1; hold(Q); host_sda = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    end
    host_sda = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    ak = ~sda_bus;
    hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic recv_bits(output logic [7:0] b);
    b = 8'h00;
    host_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(Q); scl = 1'b1; hold(Q); b = {b[6:0], sda_bus}; hold(Q); scl = 1'b0; hold(Q);
    end
  endtask

  task automatic host_ack(input logic give);
    host_sda = ~give; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q); host_sda = 1'b1;
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                           input int n, input logic [7:0] d0, input logic [7:0] d1,
                           output logic all_ack);
    logic ak;
    all_ack = 1'b1;
    bus_start;
    send_byte({a, 1'b0}, ak); all_ack &= ak;
    send_byte(idx, ak);       all_ack &= ak;
    send_byte(cnt, ak);       all_ack &= ak;
    if (n > 0) begin send_byte(d0, ak); all_ack &= ak; end
    if (n > 1) begin send_byte(d1, ak); all_ack &= ak; end
    bus_stop;
  endtask

  task automatic blk_read(input logic [6:0] a, input logic [7:0] idx, output logic [7:0] cb,
                          output logic [7:0] d [4], output logic all_ack);
    logic ak;
    int m;
    all_ack = 1'b1;
    for (int i = 0; i < 4; i++) d[i] = 8'h00;
    bus_start;
    send_byte({a, 1'b0}, ak); all_ack &= ak;
    send_byte(idx, ak);       all_ack &= ak;
    bus_start;
    send_byte({a, 1'b1}, ak); all_ack &= ak;
    recv_bits(cb);
    m = (cb > 8'd4) ? 4 : int'(cb);
    host_ack(m != 0);
    for (int i = 0; i < m; i++) begin
      recv_bits(d[i]);
      host_ack(i != m - 1);
    end
    bus_stop;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary;
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [7:0] cb, b;
    logic [7:0] rd [4];
    int s0;

    hold(5); rst_n = 1'b1; hold(5);

    // reset state
    chk("R10 sda released", sda_pull, 0);
    chk("R10 byte0", rb(0), 8'h00);
    chk("R10 byte1", rb(1), 8'hFF);
    chk("R10 byte2", rb(2), 8'h3F);
    chk("R10 byte6", rb(6), 8'h13);
    chk("R10 byte7", rb(7), 8'h42);
    chk("R10 byte8", rb(8), 8'h04);
    chk("R10 byte21", rb(21), 8'h00);

    // read length set by default count
    blk_read(7'h68, 8'h00, cb, rd, ok);
    chk("R5 ack", ok, 1);
    chk("R5 count byte", cb, 8'h04);
    chk("R5 data0", rd[0], 8'h00);
    chk("R5 data1", rd[1], 8'hFF);
    chk("R5 data2", rd[2], 8'h3F);
    chk("R5 data3", rd[3], 8'h00);

    // program count register to 2
    blk_write(7'h68, 8'h08, 8'h01, 1, 8'h02, 8'h00, ok);
    chk("R3 ack", ok, 1);
    chk("R3 byte8", rb(8), 8'h02);

    foreach (VEC[v]) begin
      logic [7:0] idx, d0, d1, e0, e1, ns;
      string tag;
      {idx, d0, d1, e0, e1, ns} = VEC[v];
      tag = (idx == 8'h06 || idx == 8'h05) ? "R7" : (idx == 8'h15 ? "R8" : "R3");
      s0 = stb_cnt;
      blk_write(7'h68, idx, 8'h02, 2, d0, d1, ok);
      chk({tag, " write ack"}, ok, 1);
      chk("R11 strobes", stb_cnt - s0, 32'(ns));
      blk_read(7'h68, idx, cb, rd, ok);
      chk("R5 read ack", ok, 1);
      chk("R5 count", cb, 8'h02);
      chk({tag, " data0"}, rd[0], e0);
      chk({tag, " data1"}, rd[1], e1);
    end

    // bytes past the count are dropped
    s0 = stb_cnt;
    blk_write(7'h68, 8'h0A, 8'h01, 2, 8'hAA, 8'hBB, ok);
    chk("R4 ack", ok, 1);
    chk("R4 byte10", rb(10), 8'hAA);
    chk("R4 byte11", rb(11), 8'h00);
    chk("R4 strobes", stb_cnt - s0, 1);

    // foreign address
    bus_start;
    send_byte({7'h38, 1'b0}, ok);
    chk("R2 nack addr", ok, 0);
    send_byte(8'h0C, ok);
    chk("R2 nack idx", ok, 0);
    send_byte(8'h01, ok);
    send_byte(8'hEE, ok);
    chk("R2 nack data", ok, 0);
    bus_stop;
    chk("R2 byte12", rb(12), 8'h00);
    chk("R2 released", sda_pull, 0);

    // strap-selected address
    addr_sel = 1'b1;
    blk_write(7'h68, 8'h0D, 8'h01, 1, 8'h5E, 8'h00, ok);
    chk("R1 old addr nack", ok, 0);
    chk("R1 byte13 kept", rb(13), 8'h00);
    blk_write(7'h60, 8'h0D, 8'h01, 1, 8'h5E, 8'h00, ok);
    chk("R1 new addr ack", ok, 1);
    chk("R1 byte13", rb(13), 8'h5E);
    addr_sel = 1'b0;

    // NACK ends a read early
    bus_start;
    send_byte({7'h68, 1'b0}, ok);
    send_byte(8'h01, ok);
    bus_start;
    send_byte({7'h68, 1'b1}, ok);
    recv_bits(cb); host_ack(1'b1);
    recv_bits(b);  host_ack(1'b0);
    chk("R6 byte read", b, 8'h3C);
    hold(Q); scl = 1'b1; hold(Q);
    chk("R6 line free", sda_bus, 1);
    hold(Q); scl = 1'b0; hold(Q);
    bus_stop;
    chk("R6 released", sda_pull, 0);

    chk("R9 edge rule", r9_viol, 0);

    // reset restores defaults
    rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
    chk("R10 byte13 after reset", rb(13), 8'h00);
    chk("R10 byte8 after reset", rb(8), 8'h04);
    chk("R10 byte1 after reset", rb(1), 8'hFF);

    done = 1;
    summary;
    $finish;
  end

endmodule